// File: doc/BRIEF.md
# AXI Write Lane Splitter (256-bit to two 128-bit ports)

This block sits between one AXI4 write master with a 256-bit data path and two AXI4 write slaves with 128-bit data paths. It does not serialise the wide data. Each wide beat is cut by byte lane instead. The lower 16 bytes of every beat go to the low port and the upper 16 bytes go to the high port. For each narrow port to see a legal incrementing burst of 16-byte transfers, the block does three things:

- It offsets the high port's start address by one half line.
- It roughly doubles the burst length on each port.
- It slots an all-zero-strobe filler beat between real beats, because those 16 bytes belong to the other port.

Only one write transaction is in flight at a time. Both ports receive the address, and the master handshake completes once both have taken it. The two write responses are merged into a single response, which carries the more severe status. Write addresses the block cannot map are refused with an error response, and their data is drained.

Top module: `axi_wr_lane_splitter`

## Requirements
- R1: Master data bits [127:0] with strobes [15:0] travel on the low port; bits [255:128] with strobes [31:16] travel on the high port.
- R2: For a master burst of N beats (AWLEN = N-1) the low port gets the master address, the master ID, AWLEN = 2N-1, AWSIZE = 4 (16 bytes) and AWBURST = 2'b01 (INCR).
- R3: The high port gets the master address plus 16, the master ID, AWLEN = 2N-2, AWSIZE = 4 and AWBURST = 2'b01.
- R4: On each port, narrow beat k (counting from 0) carries the half of master beat k/2 with that beat's strobes when k is even; when k is odd it is a filler beat with WSTRB all zero and WDATA zero.
- R5: Each port raises WLAST on its final beat only: beat 2N-1 on the low port, beat 2N-2 on the high port.
- R6: A master W beat is accepted only once both ports have taken its half; filler beats consume no master data.
- R7: The master AW handshake completes only in a cycle where both ports have accepted their address (now or earlier).
- R8: One B response goes to the master, only after both ports responded. BID is the stored AWID. BRESP is the more severe of the two responses, ranked DECERR (2'b11) > SLVERR (2'b10) > OKAY (2'b00).
- R9: While a transaction is open, up to and including its B handshake, no further master AW is accepted.
- R10: An AW with AWBURST other than 2'b01, with AWSIZE other than 5, with address bits [4:0] not zero, or with AWLEN above 127 is accepted at once. Neither port sees an AW or W beat for it. Its W beats are accepted up to WLAST, and it gets BRESP = SLVERR (2'b10).
- R11: Under back-pressure a port's WVALID stays high and its WSTRB and WLAST stay unchanged until the beat is taken. A master B response, once offered, stays offered and unchanged until taken.
- R12: After reset no valid is raised towards any port, and the master sees neither W-ready nor B-valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_awvalid | input | 1 | Master write address valid |
| m_awready | output | 1 | Master write address ready |
| m_awid | input | ID_W | Master write ID |
| m_awaddr | input | ADDR_W | Master start address |
| m_awlen | input | 8 | Master burst length minus one |
| m_awsize | input | 3 | Master transfer size code |
| m_awburst | input | 2 | Master burst type |
| m_wvalid | input | 1 | Master write data valid |
| m_wready | output | 1 | Master write data ready |
| m_wdata | input | DATA_W | Master write data |
| m_wstrb | input | DATA_W/8 | Master byte strobes |
| m_wlast | input | 1 | Master last beat |
| m_bvalid | output | 1 | Master response valid |
| m_bready | input | 1 | Master response ready |
| m_bid | output | ID_W | Master response ID |
| m_bresp | output | 2 | Merged response status |
| lo_awvalid | output | 1 | Low port address valid |
| lo_awready | input | 1 | Low port address ready |
| lo_awid | output | ID_W | Low port write ID |
| lo_awaddr | output | ADDR_W | Low port start address |
| lo_awlen | output | 8 | Low port burst length minus one |
| lo_awsize | output | 3 | Low port transfer size code |
| lo_awburst | output | 2 | Low port burst type |
| lo_wvalid | output | 1 | Low port data valid |
| lo_wready | input | 1 | Low port data ready |
| lo_wdata | output | DATA_W/2 | Low port data |
| lo_wstrb | output | DATA_W/16 | Low port strobes |
| lo_wlast | output | 1 | Low port last beat |
| lo_bvalid | input | 1 | Low port response valid |
| lo_bready | output | 1 | Low port response ready |
| lo_bresp | input | 2 | Low port response status |
| hi_awvalid | output | 1 | High port address valid |
| hi_awready | input | 1 | High port address ready |
| hi_awid | output | ID_W | High port write ID |
| hi_awaddr | output | ADDR_W | High port start address |
| hi_awlen | output | 8 | High port burst length minus one |
| hi_awsize | output | 3 | High port transfer size code |
| hi_awburst | output | 2 | High port burst type |
| hi_wvalid | output | 1 | High port data valid |
| hi_wready | input | 1 | High port data ready |
| hi_wdata | output | DATA_W/2 | High port data |
| hi_wstrb | output | DATA_W/16 | High port strobes |
| hi_wlast | output | 1 | High port last beat |
| hi_bvalid | input | 1 | High port response valid |
| hi_bready | output | 1 | High port response ready |
| hi_bresp | input | 2 | High port response status |

## Verification
The hardest case to reach is the one where one port has already taken its half of a master beat and run on through its filler beat, while the other port is still stalled on the same beat. The master beat then stays on the bus, and the fast port must not send it a second time. The stimulus reaches this by giving the two ports unrelated ready patterns (period 3 against period 4) and a stalling master, and by running bursts of up to 128 beats so that every phase alignment occurs. A second corner is a new address that arrives while responses are still outstanding. To create it, some vectors hold the master address valid for the whole transaction and delay both slave responses by several cycles.

// File: rtl/axi_wsplit_pkg.sv
package axi_wsplit_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DATA,
      ST_RESP,
      ST_DRAIN,
      ST_ERRB
   } wsplit_state_e;

   localparam logic [1:0] BURST_INCR  = 2'b01;
   localparam logic [1:0] RESP_SLVERR = 2'b10;

   // Severity order matches numeric order of the response codes.
   function automatic logic [1:0] worse_resp(input logic [1:0] a, input logic [1:0] b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/axi_wsplit_lane.sv
module axi_wsplit_lane #(
   parameter int HALF_W  = 128,
   parameter int IS_HIGH = 0,
   parameter int LEN_W   = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic [LEN_W-1:0]      mlen_i,
   input  logic                  src_valid_i,
   input  logic [HALF_W-1:0]     src_data_i,
   input  logic [HALF_W/8-1:0]   src_strb_i,
   input  logic                  src_take_i,
   output logic                  w_valid_o,
   input  logic                  w_ready_i,
   output logic [HALF_W-1:0]     w_data_o,
   output logic [HALF_W/8-1:0]   w_strb_o,
   output logic                  w_last_o,
   output logic                  taken_o,
   output logic                  busy_o
);
   localparam int CNT_W = LEN_W + 1;

   logic [CNT_W-1:0] left_q;
   logic [CNT_W-1:0] total;
   logic             fill_q;
   logic             sent_q;
   logic             hs;

   if (IS_HIGH != 0) begin : g_high
      assign total = {mlen_i, 1'b0} + CNT_W'(1);
   end else begin : g_low
      assign total = {mlen_i, 1'b0} + CNT_W'(2);
   end

   assign busy_o    = (left_q != '0);
   assign w_valid_o = busy_o & (fill_q | (src_valid_i & ~sent_q));
   assign w_last_o  = (left_q == CNT_W'(1));
   assign w_data_o  = fill_q ? '0 : src_data_i;
   assign w_strb_o  = fill_q ? '0 : src_strb_i;
   assign hs        = w_valid_o & w_ready_i;
   assign taken_o   = sent_q | (hs & ~fill_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_q <= '0;
         fill_q <= 1'b0;
         sent_q <= 1'b0;
      end else if (start_i) begin
         left_q <= total;
         fill_q <= 1'b0;
         sent_q <= 1'b0;
      end else begin
         if (hs) begin
            left_q <= left_q - CNT_W'(1);
            fill_q <= ~fill_q;
         end
         if (src_take_i)
            sent_q <= 1'b0;
         else if (hs && !fill_q)
            sent_q <= 1'b1;
      end
   end

   AST_W_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (w_valid_o && !w_ready_i) |=> (w_valid_o && $stable(w_strb_o) && $stable(w_last_o))); // R11

   AST_LAST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (hs && w_last_o) |=> !busy_o); // R5

endmodule

// File: rtl/axi_wsplit_bjoin.sv
module axi_wsplit_bjoin
   import axi_wsplit_pkg::*;
#(
   parameter int NPORT = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  collect_i,
   input  logic                  clear_i,
   input  logic [NPORT-1:0]      b_valid_i,
   input  logic [NPORT-1:0][1:0] b_resp_i,
   output logic [NPORT-1:0]      b_ready_o,
   output logic                  both_o,
   output logic [1:0]            resp_o
);
   logic [NPORT-1:0]      got_q;
   logic [NPORT-1:0][1:0] resp_q;

   for (genvar g = 0; g < NPORT; g++) begin : g_port
      assign b_ready_o[g] = collect_i & ~got_q[g];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            got_q[g]  <= 1'b0;
            resp_q[g] <= '0;
         end else if (clear_i) begin
            got_q[g]  <= 1'b0;
            resp_q[g] <= '0;
         end else if (b_valid_i[g] && b_ready_o[g]) begin
            got_q[g]  <= 1'b1;
            resp_q[g] <= b_resp_i[g];
         end
      end

      AST_GOT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
         (got_q[g] && !clear_i) |=> (got_q[g] && $stable(resp_q[g]))); // R8
   end

   always_comb begin
      resp_o = '0;
      for (int i = 0; i < NPORT; i++)
         resp_o = worse_resp(resp_o, resp_q[i]);
   end

   assign both_o = &got_q;

endmodule

// File: rtl/axi_wsplit_ctrl.sv
module axi_wsplit_ctrl
   import axi_wsplit_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int ID_W      = 4,
   parameter int LEN_W     = 8,
   parameter int WIDE_SIZE = 5,
   parameter int MAX_LEN   = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              m_awvalid,
   output logic              m_awready,
   input  logic [ID_W-1:0]   m_awid,
   input  logic [ADDR_W-1:0] m_awaddr,
   input  logic [LEN_W-1:0]  m_awlen,
   input  logic [2:0]        m_awsize,
   input  logic [1:0]        m_awburst,
   output logic [1:0]        lane_awvalid_o,
   input  logic [1:0]        lane_awready_i,
   output logic              start_o,
   input  logic              m_wvalid,
   input  logic              m_wlast,
   output logic              m_wready,
   output logic              fwd_o,
   input  logic [1:0]        lane_taken_i,
   input  logic [1:0]        lane_busy_i,
   output logic              collect_o,
   input  logic              b_both_i,
   input  logic [1:0]        b_resp_i,
   output logic              clear_o,
   output logic              m_bvalid,
   input  logic              m_bready,
   output logic [ID_W-1:0]   m_bid,
   output logic [1:0]        m_bresp
);
   wsplit_state_e   st_q;
   logic [1:0]      aw_done_q;
   logic [ID_W-1:0] id_q;
   logic            aw_ok;
   logic            aw_hs;
   logic            b_hs;

   assign aw_ok = (m_awburst == BURST_INCR) && (m_awsize == 3'(WIDE_SIZE)) &&
                  (m_awaddr[WIDE_SIZE-1:0] == '0) && (int'(m_awlen) < MAX_LEN);

   assign lane_awvalid_o = (st_q == ST_IDLE && m_awvalid && aw_ok) ? ~aw_done_q : 2'b00;
   assign m_awready = (st_q == ST_IDLE) &&
                      (!aw_ok || (&((lane_awvalid_o & lane_awready_i) | aw_done_q)));
   assign aw_hs     = m_awvalid & m_awready;
   assign start_o   = aw_hs & aw_ok;

   assign fwd_o     = (st_q == ST_DATA);
   assign m_wready  = (fwd_o && (&lane_taken_i)) || (st_q == ST_DRAIN);
   assign collect_o = (st_q == ST_DATA) || (st_q == ST_RESP);
   assign m_bvalid  = (st_q == ST_ERRB) || (st_q == ST_RESP && b_both_i);
   assign m_bresp   = (st_q == ST_ERRB) ? RESP_SLVERR : b_resp_i;
   assign m_bid     = id_q;
   assign b_hs      = m_bvalid & m_bready;
   assign clear_o   = b_hs && (st_q == ST_RESP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         aw_done_q <= '0;
         id_q      <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (aw_hs) begin
                  aw_done_q <= '0;
                  id_q      <= m_awid;
                  st_q      <= aw_ok ? ST_DATA : ST_DRAIN;
               end else begin
                  aw_done_q <= aw_done_q | (lane_awvalid_o & lane_awready_i);
               end
            end
            ST_DATA:  if (lane_busy_i == '0) st_q <= ST_RESP;
            ST_RESP:  if (b_hs) st_q <= ST_IDLE;
            ST_DRAIN: if (m_wvalid && m_wlast) st_q <= ST_ERRB;
            ST_ERRB:  if (b_hs) st_q <= ST_IDLE;
            default:  st_q <= ST_IDLE;
         endcase
      end
   end

   AST_ONE_TXN: assert property (@(posedge clk) disable iff (!rst_n)
      (|lane_busy_i) |-> !m_awready); // R9

   AST_DRAIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DRAIN || st_q == ST_ERRB) |-> (lane_busy_i == '0)); // R10

   AST_B_AFTER_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      m_bvalid |-> (lane_busy_i == '0)); // R8

   AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (m_bvalid && !m_bready) |=> (m_bvalid && $stable(m_bresp) && $stable(m_bid))); // R11

endmodule

// File: rtl/axi_wr_lane_splitter.sv
module axi_wr_lane_splitter
   import axi_wsplit_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int ID_W   = 4,
   parameter int DATA_W = 256
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   m_awvalid,
   output logic                   m_awready,
   input  logic [ID_W-1:0]        m_awid,
   input  logic [ADDR_W-1:0]      m_awaddr,
   input  logic [7:0]             m_awlen,
   input  logic [2:0]             m_awsize,
   input  logic [1:0]             m_awburst,
   input  logic                   m_wvalid,
   output logic                   m_wready,
   input  logic [DATA_W-1:0]      m_wdata,
   input  logic [DATA_W/8-1:0]    m_wstrb,
   input  logic                   m_wlast,
   output logic                   m_bvalid,
   input  logic                   m_bready,
   output logic [ID_W-1:0]        m_bid,
   output logic [1:0]             m_bresp,
   output logic                   lo_awvalid,
   input  logic                   lo_awready,
   output logic [ID_W-1:0]        lo_awid,
   output logic [ADDR_W-1:0]      lo_awaddr,
   output logic [7:0]             lo_awlen,
   output logic [2:0]             lo_awsize,
   output logic [1:0]             lo_awburst,
   output logic                   lo_wvalid,
   input  logic                   lo_wready,
   output logic [DATA_W/2-1:0]    lo_wdata,
   output logic [DATA_W/16-1:0]   lo_wstrb,
   output logic                   lo_wlast,
   input  logic                   lo_bvalid,
   output logic                   lo_bready,
   input  logic [1:0]             lo_bresp,
   output logic                   hi_awvalid,
   input  logic                   hi_awready,
   output logic [ID_W-1:0]        hi_awid,
   output logic [ADDR_W-1:0]      hi_awaddr,
   output logic [7:0]             hi_awlen,
   output logic [2:0]             hi_awsize,
   output logic [1:0]             hi_awburst,
   output logic                   hi_wvalid,
   input  logic                   hi_wready,
   output logic [DATA_W/2-1:0]    hi_wdata,
   output logic [DATA_W/16-1:0]   hi_wstrb,
   output logic                   hi_wlast,
   input  logic                   hi_bvalid,
   output logic                   hi_bready,
   input  logic [1:0]             hi_bresp
);
   localparam int LEN_W       = 8;
   localparam int HALF_W      = DATA_W / 2;
   localparam int STRB_W      = DATA_W / 8;
   localparam int HSTRB_W     = STRB_W / 2;
   localparam int WIDE_SIZE   = $clog2(STRB_W);
   localparam int NARROW_SIZE = WIDE_SIZE - 1;
   localparam int MAX_LEN     = (1 << LEN_W) / 2;

   if (DATA_W < 64 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("DATA_W must be a power of two of at least 64");
   end
   if (DATA_W > 1024) begin : g_too_wide
      $error("DATA_W above the largest AXI data width");
   end

   logic [1:0]        lane_awvalid, lane_awready, lane_wvalid, lane_wready;
   logic [1:0]        lane_wlast, lane_taken, lane_busy, lane_bready;
   logic [HALF_W-1:0] lane_wdata [2];
   logic [HSTRB_W-1:0] lane_wstrb [2];
   logic              start, fwd, collect, clear, b_both;
   logic [1:0]        b_resp;
   logic              take;

   assign lane_awready = {hi_awready, lo_awready};
   assign lane_wready  = {hi_wready, lo_wready};
   assign take         = m_wvalid & m_wready & fwd;

   axi_wsplit_ctrl #(
      .ADDR_W(ADDR_W), .ID_W(ID_W), .LEN_W(LEN_W),
      .WIDE_SIZE(WIDE_SIZE), .MAX_LEN(MAX_LEN)
   ) ctrl_i (
      .clk(clk), .rst_n(rst_n),
      .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awid(m_awid),
      .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awsize(m_awsize), .m_awburst(m_awburst),
      .lane_awvalid_o(lane_awvalid), .lane_awready_i(lane_awready), .start_o(start),
      .m_wvalid(m_wvalid), .m_wlast(m_wlast), .m_wready(m_wready), .fwd_o(fwd),
      .lane_taken_i(lane_taken), .lane_busy_i(lane_busy),
      .collect_o(collect), .b_both_i(b_both), .b_resp_i(b_resp), .clear_o(clear),
      .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bid(m_bid), .m_bresp(m_bresp)
   );

   for (genvar g = 0; g < 2; g++) begin : g_lane
      axi_wsplit_lane #(.HALF_W(HALF_W), .IS_HIGH(g), .LEN_W(LEN_W)) lane_i (
         .clk(clk), .rst_n(rst_n), .start_i(start), .mlen_i(m_awlen),
         .src_valid_i(m_wvalid),
         .src_data_i(m_wdata[g*HALF_W +: HALF_W]),
         .src_strb_i(m_wstrb[g*HSTRB_W +: HSTRB_W]),
         .src_take_i(take),
         .w_valid_o(lane_wvalid[g]), .w_ready_i(lane_wready[g]),
         .w_data_o(lane_wdata[g]), .w_strb_o(lane_wstrb[g]), .w_last_o(lane_wlast[g]),
         .taken_o(lane_taken[g]), .busy_o(lane_busy[g])
      );
   end

   axi_wsplit_bjoin #(.NPORT(2)) bjoin_i (
      .clk(clk), .rst_n(rst_n), .collect_i(collect), .clear_i(clear),
      .b_valid_i({hi_bvalid, lo_bvalid}), .b_resp_i({hi_bresp, lo_bresp}),
      .b_ready_o(lane_bready), .both_o(b_both), .resp_o(b_resp)
   );

   assign lo_awvalid = lane_awvalid[0];
   assign lo_awid    = m_awid;
   assign lo_awaddr  = m_awaddr;
   assign lo_awlen   = {m_awlen[LEN_W-2:0], 1'b1};
   assign lo_awsize  = 3'(NARROW_SIZE);
   assign lo_awburst = BURST_INCR;
   assign lo_wvalid  = lane_wvalid[0];
   assign lo_wdata   = lane_wdata[0];
   assign lo_wstrb   = lane_wstrb[0];
   assign lo_wlast   = lane_wlast[0];
   assign lo_bready  = lane_bready[0];

   assign hi_awvalid = lane_awvalid[1];
   assign hi_awid    = m_awid;
   assign hi_awaddr  = m_awaddr + ADDR_W'(HSTRB_W);
   assign hi_awlen   = {m_awlen[LEN_W-2:0], 1'b0};
   assign hi_awsize  = 3'(NARROW_SIZE);
   assign hi_awburst = BURST_INCR;
   assign hi_wvalid  = lane_wvalid[1];
   assign hi_wdata   = lane_wdata[1];
   assign hi_wstrb   = lane_wstrb[1];
   assign hi_wlast   = lane_wlast[1];
   assign hi_bready  = lane_bready[1];

   AST_AW_BOTH_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      (m_awvalid && m_awready && start) |=> (lane_busy == 2'b11)); // R7

endmodule

// File: tb/axi_wr_lane_splitter_tb.sv
module axi_wr_lane_splitter_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic m_awvalid = 0, m_awready; logic [3:0] m_awid = 0; logic [31:0] m_awaddr = 0;
   logic [7:0] m_awlen = 0; logic [2:0] m_awsize = 0; logic [1:0] m_awburst = 0;
   logic m_wvalid = 0, m_wready; logic [255:0] m_wdata = 0; logic [31:0] m_wstrb = 0;
   logic m_wlast = 0, m_bvalid, m_bready = 0; logic [3:0] m_bid; logic [1:0] m_bresp;
   logic lo_awvalid, lo_awready = 0; logic [3:0] lo_awid; logic [31:0] lo_awaddr;
   logic [7:0] lo_awlen; logic [2:0] lo_awsize; logic [1:0] lo_awburst;
   logic lo_wvalid, lo_wready = 0; logic [127:0] lo_wdata; logic [15:0] lo_wstrb;
   logic lo_wlast, lo_bvalid = 0, lo_bready; logic [1:0] lo_bresp = 0;
   logic hi_awvalid, hi_awready = 0; logic [3:0] hi_awid; logic [31:0] hi_awaddr;
   logic [7:0] hi_awlen; logic [2:0] hi_awsize; logic [1:0] hi_awburst;
   logic hi_wvalid, hi_wready = 0; logic [127:0] hi_wdata; logic [15:0] hi_wstrb;
   logic hi_wlast, hi_bvalid = 0, hi_bready; logic [1:0] hi_bresp = 0;

   axi_wr_lane_splitter dut_i (.*);

   typedef struct packed {
      logic [7:0]  len;   logic [31:0] addr;  logic [2:0] size;  logic [1:0] burst;
      logic [31:0] strb;  logic [1:0]  rlo;   logic [1:0] rhi;   logic bp;
      logic        probe; logic [1:0]  exp;   logic legal;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{len:8'd3,   addr:32'h0000_0000, size:3'd5, burst:2'b01, strb:32'hFFFF_FFFF, rlo:2'b00, rhi:2'b00, bp:1'b0, probe:1'b0, exp:2'b00, legal:1'b1},
      '{len:8'd0,   addr:32'h0000_1000, size:3'd5, burst:2'b01, strb:32'h0000_FFFF, rlo:2'b00, rhi:2'b10, bp:1'b1, probe:1'b1, exp:2'b10, legal:1'b1},
      '{len:8'd7,   addr:32'h0000_2040, size:3'd5, burst:2'b01, strb:32'hF0F0_0F0F, rlo:2'b11, rhi:2'b10, bp:1'b1, probe:1'b0, exp:2'b11, legal:1'b1},
      '{len:8'd127, addr:32'h0001_0000, size:3'd5, burst:2'b01, strb:32'h8001_7FFE, rlo:2'b00, rhi:2'b00, bp:1'b1, probe:1'b0, exp:2'b00, legal:1'b1},
      '{len:8'd128, addr:32'h0002_0000, size:3'd5, burst:2'b01, strb:32'hFFFF_FFFF, rlo:2'b00, rhi:2'b00, bp:1'b0, probe:1'b0, exp:2'b10, legal:1'b0},
      '{len:8'd1,   addr:32'h0000_0030, size:3'd5, burst:2'b01, strb:32'hFFFF_FFFF, rlo:2'b00, rhi:2'b00, bp:1'b1, probe:1'b0, exp:2'b10, legal:1'b0},
      '{len:8'd2,   addr:32'h0000_0100, size:3'd5, burst:2'b10, strb:32'hFFFF_FFFF, rlo:2'b00, rhi:2'b00, bp:1'b0, probe:1'b0, exp:2'b10, legal:1'b0},
      '{len:8'd2,   addr:32'h0000_0200, size:3'd4, burst:2'b01, strb:32'hFFFF_FFFF, rlo:2'b00, rhi:2'b00, bp:1'b0, probe:1'b0, exp:2'b10, legal:1'b0},
      '{len:8'd2,   addr:32'h0000_0080, size:3'd5, burst:2'b01, strb:32'h1234_5678, rlo:2'b00, rhi:2'b11, bp:1'b0, probe:1'b1, exp:2'b11, legal:1'b1},
      '{len:8'd5,   addr:32'h0000_0400, size:3'd5, burst:2'b01, strb:32'hFFFF_0000, rlo:2'b10, rhi:2'b00, bp:1'b1, probe:1'b1, exp:2'b10, legal:1'b1}
   };

   int n_chk = 0, n_fail = 0;
   int aw_sent, wbeat, bdone, wpend, probe_err, r7_err, cyc;
   int l_aw [2], l_beats [2], l_err [2], l_lerr [2], l_hold [2], l_bpend [2], l_bdly [2];
   logic l_pv [2]; logic [15:0] l_ps [2]; logic l_pl [2];
   logic [31:0] l_addr [2]; logic [7:0] l_len [2]; logic [2:0] l_size [2];
   logic [1:0] l_burst [2]; logic [3:0] l_id [2];
   logic [1:0] got_resp; logic [3:0] got_id;

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [255:0] mdata(input int t, input int b);
      logic [255:0] r;
      for (int i = 0; i < 8; i++) r[i*32 +: 32] = 32'(t * 4096 + b * 16 + i) ^ 32'hA5C3_0000;
      return r;
   endfunction

   task automatic lane_beat(input int l, input logic [15:0] s, input logic [127:0] d,
                            input logic last, input vec_t v, input int t);
      int k, total;
      logic [255:0] full;
      k = l_beats[l];
      total = (l == 0) ? 2 * (int'(v.len) + 1) : 2 * (int'(v.len) + 1) - 1;
      if (k % 2 == 0) begin
         full = mdata(t, k / 2);
         if (s != v.strb[l*16 +: 16] || d != full[l*128 +: 128]) l_err[l]++;
      end else if (s != 16'h0 || d != 128'h0) l_err[l]++;
      if (last != (k == total - 1)) l_lerr[l]++;
      if (last) begin l_bpend[l] = 1; l_bdly[l] = v.probe ? 8 : (l == 0 ? 3 : 1); end
      l_beats[l]++;
   endtask

   task automatic run_vec(input vec_t v, input int t);
      aw_sent = 0; wbeat = 0; bdone = 0; wpend = 0; probe_err = 0; r7_err = 0; cyc = 0;
      for (int l = 0; l < 2; l++) begin
         l_aw[l] = 0; l_beats[l] = 0; l_err[l] = 0; l_lerr[l] = 0; l_hold[l] = 0;
         l_bpend[l] = 0; l_bdly[l] = 0; l_pv[l] = 0;
      end
      while (bdone == 0 && cyc < 6000) begin
         @(negedge clk); cyc++;
         m_awvalid = (aw_sent == 0) || (v.probe && bdone == 0);
         m_awid = 4'(t); m_awaddr = v.addr; m_awlen = v.len; m_awsize = v.size; m_awburst = v.burst;
         m_wvalid = (wbeat <= int'(v.len)) && (wpend != 0 || !v.bp || cyc % 3 != 2);
         m_wdata = mdata(t, wbeat); m_wstrb = v.strb; m_wlast = (wbeat == int'(v.len));
         m_bready = !v.bp || (cyc % 2 == 0);
         lo_awready = !v.bp || (cyc % 2 == 0); hi_awready = !v.bp || (cyc % 3 == 1);
         lo_wready = !v.bp || (cyc % 3 != 0);  hi_wready = !v.bp || (cyc % 4 != 1);
         lo_bvalid = (l_bpend[0] != 0) && (l_bdly[0] == 0); lo_bresp = v.rlo;
         hi_bvalid = (l_bpend[1] != 0) && (l_bdly[1] == 0); hi_bresp = v.rhi;
         #3;
         if (m_awvalid && m_awready) begin
            if (aw_sent != 0) probe_err++;
            if (v.legal && ((l_aw[0] + int'(lo_awvalid && lo_awready)) == 0 ||
                            (l_aw[1] + int'(hi_awvalid && hi_awready)) == 0)) r7_err++;
            aw_sent = 1;
         end
         if (lo_awvalid && lo_awready) begin
            l_aw[0]++; l_addr[0] = lo_awaddr; l_len[0] = lo_awlen; l_size[0] = lo_awsize;
            l_burst[0] = lo_awburst; l_id[0] = lo_awid;
         end
         if (hi_awvalid && hi_awready) begin
            l_aw[1]++; l_addr[1] = hi_awaddr; l_len[1] = hi_awlen; l_size[1] = hi_awsize;
            l_burst[1] = hi_awburst; l_id[1] = hi_awid;
         end
         if (l_pv[0] && !(lo_wvalid && lo_wstrb == l_ps[0] && lo_wlast == l_pl[0])) l_hold[0]++;
         if (l_pv[1] && !(hi_wvalid && hi_wstrb == l_ps[1] && hi_wlast == l_pl[1])) l_hold[1]++;
         l_pv[0] = lo_wvalid && !lo_wready; l_ps[0] = lo_wstrb; l_pl[0] = lo_wlast;
         l_pv[1] = hi_wvalid && !hi_wready; l_ps[1] = hi_wstrb; l_pl[1] = hi_wlast;
         if (lo_wvalid && lo_wready) lane_beat(0, lo_wstrb, lo_wdata, lo_wlast, v, t);
         if (hi_wvalid && hi_wready) lane_beat(1, hi_wstrb, hi_wdata, hi_wlast, v, t);
         if (lo_bvalid && lo_bready) l_bpend[0] = 0;
         if (hi_bvalid && hi_bready) l_bpend[1] = 0;
         for (int l = 0; l < 2; l++) if (l_bpend[l] != 0 && l_bdly[l] > 0) l_bdly[l]--;
         wpend = (m_wvalid && !m_wready) ? 1 : 0;
         if (m_wvalid && m_wready) wbeat++;
         if (m_bvalid && m_bready) begin bdone = 1; got_resp = m_bresp; got_id = m_bid; end
      end
      @(negedge clk);
      m_awvalid = 0; m_wvalid = 0; m_bready = 0; lo_bvalid = 0; hi_bvalid = 0;
      check(bdone != 0, $sformatf("watchdog R8 vector %0d", t), 64'(cyc), 64'd6000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #3;
      // R12: reset state
      check(!lo_awvalid && !hi_awvalid && !lo_wvalid && !hi_wvalid && !m_bvalid && !m_wready,
            "R12 outputs quiet in reset",
            64'({lo_awvalid, hi_awvalid, lo_wvalid, hi_wvalid, m_bvalid, m_wready}), 64'd0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk); #3;
      check(!lo_awvalid && !hi_awvalid && !lo_wvalid && !hi_wvalid && !m_bvalid && !m_wready,
            "R12 outputs quiet after reset",
            64'({lo_awvalid, hi_awvalid, lo_wvalid, hi_wvalid, m_bvalid, m_wready}), 64'd0);

      for (int t = 0; t < NV; t++) begin
         vec_t v;
         int n;
         v = VECS[t];
         n = int'(v.len) + 1;
         run_vec(v, t);
         check(got_resp == v.exp, $sformatf("R8 R10 bresp vector %0d", t), 64'(got_resp), 64'(v.exp));
         check(got_id == 4'(t), $sformatf("R8 bid vector %0d", t), 64'(got_id), 64'(t));
         check(wbeat == n, $sformatf("R6 R10 master beats vector %0d", t), 64'(wbeat), 64'(n));
         if (v.legal) begin
            check(l_aw[0] == 1 && l_aw[1] == 1 && r7_err == 0, $sformatf("R7 aw pairing vector %0d", t),
                  64'(l_aw[0] * 256 + l_aw[1] * 16 + r7_err), 64'h110);
            check(l_addr[0] == v.addr && l_len[0] == 8'(2 * n - 1) && l_size[0] == 3'd4 &&
                  l_burst[0] == 2'b01 && l_id[0] == 4'(t), $sformatf("R2 low aw vector %0d", t),
                  64'({l_addr[0], l_len[0]}), 64'({v.addr, 8'(2 * n - 1)}));
            check(l_addr[1] == v.addr + 32'd16 && l_len[1] == 8'(2 * n - 2) && l_size[1] == 3'd4 &&
                  l_burst[1] == 2'b01 && l_id[1] == 4'(t), $sformatf("R3 high aw vector %0d", t),
                  64'({l_addr[1], l_len[1]}), 64'({v.addr + 32'd16, 8'(2 * n - 2)}));
            check(l_beats[0] == 2 * n && l_beats[1] == 2 * n - 1, $sformatf("R4 beat counts vector %0d", t),
                  64'(l_beats[0] * 1024 + l_beats[1]), 64'(2 * n * 1024 + 2 * n - 1));
            check(l_err[0] == 0 && l_err[1] == 0, $sformatf("R1 R4 lane contents vector %0d", t),
                  64'(l_err[0] + l_err[1]), 64'd0);
            check(l_lerr[0] == 0 && l_lerr[1] == 0, $sformatf("R5 wlast placement vector %0d", t),
                  64'(l_lerr[0] + l_lerr[1]), 64'd0);
            check(l_hold[0] == 0 && l_hold[1] == 0, $sformatf("R11 w hold vector %0d", t),
                  64'(l_hold[0] + l_hold[1]), 64'd0);
         end else begin
            check(l_aw[0] + l_aw[1] + l_beats[0] + l_beats[1] == 0,
                  $sformatf("R10 ports silent vector %0d", t),
                  64'(l_aw[0] + l_aw[1] + l_beats[0] + l_beats[1]), 64'd0);
         end
         if (v.probe)
            check(probe_err == 0, $sformatf("R9 second aw held off vector %0d", t), 64'(probe_err), 64'd0);
      end

      // R12: reset in the middle of a transaction returns the ports to quiet
      @(negedge clk);
      m_awvalid = 1; m_awid = 4'd9; m_awaddr = 32'h40; m_awlen = 8'd3; m_awsize = 3'd5; m_awburst = 2'b01;
      lo_awready = 1; hi_awready = 1;
      @(negedge clk); m_awvalid = 0;
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1; #3;
      check(!lo_wvalid && !hi_wvalid && !m_bvalid && !m_wready, "R12 quiet after mid-burst reset",
            64'({lo_wvalid, hi_wvalid, m_bvalid, m_wready}), 64'd0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(8 * 190000);
      n_chk++; n_fail++;
      $display("FAIL watchdog R8 bench did not finish actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule